// File: doc/BRIEF.md
# I2C Register-Access Slave with Address Pointer

This block is an I2C slave front end. It gives a bus master read and write access to an internal file of 8-bit registers. It runs from a system clock that is much faster than the bus. SCL and SDA are synchronized and oversampled, and the block detects START, repeated START and STOP from edges of the synchronized lines. It matches a 7-bit device address, and one strap pin picks the lowest bit of that address.

After an acknowledged write address, the first byte loads an internal register pointer. Each further byte is written through a one-cycle write strobe. A read is a write of the pointer followed by a repeated START and the device address with the read bit set. The block fetches each byte through a one-cycle read strobe before it has to shift the byte out.

The pointer advances after every data byte. One register, the hold address, is a stream location: a burst that starts there stays there. A burst that starts anywhere else steps over it.

The register-file side is a plain strobe port. On a write strobe the file stores `reg_wdata` at `reg_addr`. On a read strobe the file returns the addressed byte on `reg_rdata` one clock later.

Top module: `i2c_regif_slave`

## Requirements
- R1: The device address is 0x40 when `addr_strap` is low in the first clock after reset release, and 0x41 when it is high. Changes of `addr_strap` after that have no effect until the next reset.
- R2: A START is a falling SDA while SCL is high, and a STOP is a rising SDA while SCL is high. The slave acknowledges nothing, strobes nothing and drives nothing until a START is seen. A repeated START restarts address matching.
- R3: `sda_oe` (1 = pull SDA low) changes only while SCL is low. Bits are taken on the rising edge of SCL and sent MSB first.
- R4: After a matched address with R/W = 0, the next byte is acknowledged and its low 7 bits load the pointer. A read is that write followed by a repeated START and the address with R/W = 1.
- R5: Each data byte written produces one `reg_we` pulse at the pointer's current value. The pointer then advances by one and wraps from 0x7F to 0x00.
- R6: The pointer does not advance from 0x44. An advance from any other address never lands on 0x44: 0x43 is followed by 0x45.
- R7: During a read, a master NACK makes the slave release SDA and go idle. Further SCL clocks without a START get no response.
- R8: A device-address mismatch is not acknowledged, and the rest of that transaction produces no acknowledge and no strobe.
- R9: A STOP ends a write. Bytes clocked after it without a new START write nothing. `reg_we` and `reg_re` are never high together and `reg_we` never lasts two clocks.
- R10: One `reg_re` is issued when a read address is acknowledged and one after each byte that the master ACKs, none after a NACK. Each byte shifted out equals the register at the pointer.
- R11: While reset is low and after its release, `sda_oe`, `reg_we` and `reg_re` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Device address bit 0, captured once after reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | AW (7) | Register pointer |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-clock write strobe |
| reg_re | output | 1 | One-clock read strobe |
| reg_rdata | input | 8 | Read data, valid the clock after `reg_re` |

## Verification
Every bus event reaches the logic three clocks after the pin moves: two synchronizer stages and one history flop. An acknowledge or a data bit therefore appears on `sda_oe` about three clocks after the master lowers SCL. The bench drives SCL with a quarter-period of ten clocks and samples SDA in the middle of the high phase, well after that delay.

Write and read strobes come one and two clocks after the internal event, and the prefetched byte is loaded four clocks after an acknowledge. The bench therefore logs strobes continuously and compares the logs only after the transaction has finished. A separate monitor flags any change of `sda_oe` that occurs while SCL has been high for two clocks.

// File: rtl/i2c_regif_pkg.sv
`timescale 1ns/1ps
package i2c_regif_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_MWAIT
   } slv_state_t;

   typedef enum logic [1:0] {
      K_DEV,
      K_REG,
      K_DAT
   } rx_kind_t;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] lvl,
   output logic [LINES-1:0] rise,
   output logic [LINES-1:0] fall
);
   if (STAGES < 2) begin : g_stage_chk
      $error("i2c_line_sync: at least two synchronizer stages required");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      // STAGES synchronizer flops plus one history flop for edge flags
      logic [STAGES:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-1:0], din[g]};
      end
      assign lvl[g]  = chain[STAGES-1];
      assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
      assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
   end
endmodule

// File: rtl/i2c_regif_ptr.sv
`timescale 1ns/1ps
module i2c_regif_ptr #(
   parameter int AW        = 7,
   parameter int HOLD_ADDR = 68
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          adv,
   output logic [AW-1:0] cnt
);
   localparam logic [AW-1:0] HOLD = HOLD_ADDR[AW-1:0];
   localparam logic [AW-1:0] WRAP = (HOLD == '0) ? AW'(1) : '0;

   if (HOLD_ADDR >= (1 << AW)) begin : g_hold_chk
      $error("i2c_regif_ptr: HOLD_ADDR outside pointer range");
   end

   function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
      logic [AW-1:0] n;
      n = a + 1'b1;
      if (n == HOLD) n = n + 1'b1;
      return n;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= load_val;
      else if (adv && cnt != HOLD) cnt <= step(cnt);
   end

   p_hold_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && cnt == HOLD) |=> (cnt == HOLD));
   p_skip_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && cnt != HOLD) |=> (cnt != HOLD));
   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && cnt == '1 && cnt != HOLD) |=> (cnt == WRAP));
endmodule

// File: rtl/i2c_regif_slave.sv
`timescale 1ns/1ps
module i2c_regif_slave #(
   parameter int CLK_HZ      = 100_000_000,
   parameter int BUS_HZ      = 400_000,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 7,
   parameter int DEV_BASE    = 'h40,
   parameter int HOLD_ADDR   = 'h44
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          addr_strap,
   input  logic          scl_in,
   input  logic          sda_in,
   output logic          sda_oe,
   output logic [AW-1:0] reg_addr,
   output logic [7:0]    reg_wdata,
   output logic          reg_we,
   output logic          reg_re,
   input  logic [7:0]    reg_rdata
);
   import i2c_regif_pkg::*;

   localparam logic [6:0] BASE7 = DEV_BASE[6:0];

   if (CLK_HZ < 16 * BUS_HZ) begin : g_rate_chk
      $error("i2c_regif_slave: system clock below 16x bus rate");
   end
   if (AW < 1 || AW > BYTE_W) begin : g_aw_chk
      $error("i2c_regif_slave: AW must be 1..8");
   end
   if (DEV_BASE[0] != 1'b0 || DEV_BASE > 'h7F) begin : g_base_chk
      $error("i2c_regif_slave: DEV_BASE must be a 7-bit even value");
   end

   // ---------------- line conditioning ----------------
   logic [1:0] lvl, rise, fall;
   i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({scl_in, sda_in}),
      .lvl  (lvl),
      .rise (rise),
      .fall (fall)
   );
   logic scl_s, sda_s, scl_r, scl_f, start_c, stop_c;
   assign scl_s   = lvl[1];
   assign sda_s   = lvl[0];
   assign scl_r   = rise[1];
   assign scl_f   = fall[1];
   assign start_c = scl_s & fall[0];
   assign stop_c  = scl_s & rise[0];

   // ---------------- strap capture ----------------
   logic strap_done, strap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_done <= 1'b0;
         strap_q    <= 1'b0;
      end else if (!strap_done) begin
         strap_done <= 1'b1;
         strap_q    <= addr_strap;
      end
   end
   logic [6:0] own_addr;
   assign own_addr = BASE7 | {6'b0, strap_q};

   // ---------------- protocol engine ----------------
   slv_state_t state;
   rx_kind_t   kind;
   logic [2:0] bitcnt;
   logic [7:0] rx_sh, tx_sh, tx_buf, wdata_q;
   logic       full, rw_q;
   logic       we_q, adv_q, load_q, fetch_q, re_q, cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         kind    <= K_DEV;
         bitcnt  <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         tx_buf  <= '0;
         wdata_q <= '0;
         full    <= 1'b0;
         rw_q    <= 1'b0;
         we_q    <= 1'b0;
         adv_q   <= 1'b0;
         load_q  <= 1'b0;
         fetch_q <= 1'b0;
         re_q    <= 1'b0;
         cap_q   <= 1'b0;
      end else begin
         we_q    <= 1'b0;
         adv_q   <= 1'b0;
         load_q  <= 1'b0;
         fetch_q <= 1'b0;
         re_q    <= fetch_q;
         cap_q   <= re_q;
         if (cap_q) tx_buf <= reg_rdata;

         if (start_c) begin
            state  <= ST_RX;
            kind   <= K_DEV;
            bitcnt <= '0;
            full   <= 1'b0;
         end else if (stop_c) begin
            state <= ST_IDLE;
            full  <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_RX: begin
                  if (scl_r && !full) begin
                     rx_sh  <= {rx_sh[6:0], sda_s};
                     bitcnt <= bitcnt + 3'd1;
                     if (bitcnt == 3'd7) full <= 1'b1;
                  end else if (scl_f && full) begin
                     full   <= 1'b0;
                     bitcnt <= '0;
                     unique case (kind)
                        K_DEV: begin
                           if (rx_sh[7:1] == own_addr) begin
                              rw_q  <= rx_sh[0];
                              state <= ST_ACK;
                              if (rx_sh[0]) fetch_q <= 1'b1;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        K_REG: begin
                           load_q <= 1'b1;
                           state  <= ST_ACK;
                        end
                        default: begin
                           we_q    <= 1'b1;
                           wdata_q <= rx_sh;
                           adv_q   <= 1'b1;
                           state   <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_f) begin
                     bitcnt <= '0;
                     if (kind == K_DEV && rw_q) begin
                        state <= ST_TX;
                        tx_sh <= tx_buf;
                     end else begin
                        state <= ST_RX;
                        kind  <= (kind == K_DEV) ? K_REG : K_DAT;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_f) begin
                     if (bitcnt == 3'd7) begin
                        state <= ST_MACK;
                     end else begin
                        bitcnt <= bitcnt + 3'd1;
                        tx_sh  <= {tx_sh[6:0], 1'b0};
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_r) begin
                     if (sda_s) begin
                        state <= ST_IDLE;
                     end else begin
                        adv_q   <= 1'b1;
                        fetch_q <= 1'b1;
                        state   <= ST_MWAIT;
                     end
                  end
               end
               ST_MWAIT: begin
                  if (scl_f) begin
                     state  <= ST_TX;
                     bitcnt <= '0;
                     tx_sh  <= tx_buf;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // ---------------- register pointer ----------------
   i2c_regif_ptr #(.AW(AW), .HOLD_ADDR(HOLD_ADDR)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load_q),
      .load_val(rx_sh[AW-1:0]),
      .adv     (adv_q),
      .cnt     (reg_addr)
   );

   assign sda_oe    = (state == ST_ACK) | ((state == ST_TX) & ~tx_sh[7]);
   assign reg_wdata = wdata_q;
   assign reg_we    = we_q;
   assign reg_re    = re_q;

   // ---------------- assertions ----------------
   p_strap_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      strap_done |=> $stable(strap_q));
   p_wait_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !start_c) |=> (state == ST_IDLE));
   p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_s));
   p_nack_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MACK && scl_r && sda_s && !start_c && !stop_c) |=> (state == ST_IDLE && !sda_oe));
   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));
   p_we_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
endmodule

// File: tb/i2c_regif_slave_bench.sv
`timescale 1ns/1ps
module i2c_regif_slave_bench;
   localparam int Q  = 10;
   localparam int AW = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strap = 1'b1;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_line;
   logic sda_oe, reg_we, reg_re;
   logic [AW-1:0] reg_addr;
   logic [7:0] reg_wdata, rdata;

   always #2.5 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   i2c_regif_slave #(.CLK_HZ(200_000_000), .BUS_HZ(5_000_000)) u_i2c_regif_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_strap(strap),
      .scl_in    (m_scl),
      .sda_in    (sda_line),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_rdata (rdata)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0, wn = 0, rn = 0, r3_bad = 0;
   bit done = 0;
   logic [6:0] wa [0:63];
   logic [7:0] wd [0:63];
   logic [6:0] ra [0:63];
   logic [7:0] mem [0:127];
   logic [7:0] rbuf [0:7];
   logic oe_prev = 1'b0, scl_prev = 1'b1;
   logic [6:0] dev = 7'h41;

   function automatic logic [7:0] init_val(input int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   function automatic logic [6:0] nxt(input logic [6:0] a);
      logic [6:0] n;
      if (a == 7'h44) return a;
      n = a + 7'd1;
      if (n == 7'h44) n = 7'h45;
      return n;
   endfunction

   // register file model and strobe logs
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
         rdata <= '0;
      end else begin
         if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            if (wn < 64) begin wa[wn] <= reg_addr; wd[wn] <= reg_wdata; end
            wn <= wn + 1;
         end
         if (reg_re) begin
            rdata <= mem[reg_addr];
            if (rn < 64) ra[rn] <= reg_addr;
            rn <= rn + 1;
         end
         if (sda_oe !== oe_prev && m_scl && scl_prev) r3_bad <= r3_bad + 1;
      end
      oe_prev  <= sda_oe;
      scl_prev <= m_scl;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190_000 && !done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL ALL watchdog actual=%0d expected=<%0d", cyc, 190_000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic waitq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq();
      m_sda = 1'b0; waitq(); m_scl = 1'b0; waitq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; waitq(); m_scl = 1'b1; waitq(); m_sda = 1'b1; waitq();
   endtask

   task automatic bit_out(input logic b);
      m_sda = b; waitq(); m_scl = 1'b1; waitq(); waitq(); m_scl = 1'b0; waitq();
   endtask

   task automatic bit_in(output logic b);
      m_sda = 1'b1; waitq(); m_scl = 1'b1; waitq(); b = sda_line; waitq(); m_scl = 1'b0; waitq();
   endtask

   task automatic byte_out(input logic [7:0] v, output int ack);
      logic b;
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(b);
      ack = b ? 0 : 1;
   endtask

   task automatic byte_in(output logic [7:0] v, input bit mack);
      logic b;
      for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
      bit_out(!mack);
   endtask

   task automatic do_write(input logic [7:0] rg, input int n, input logic [7:0] base, output int acks);
      int a;
      acks = 0;
      bus_start();
      byte_out({dev, 1'b0}, a); acks += a;
      byte_out(rg, a); acks += a;
      for (int k = 0; k < n; k++) begin byte_out(base + 8'(k), a); acks += a; end
      bus_stop();
   endtask

   task automatic do_read(input logic [7:0] rg, input int n, output int acks);
      int a;
      logic [7:0] v;
      acks = 0;
      bus_start();
      byte_out({dev, 1'b0}, a); acks += a;
      byte_out(rg, a); acks += a;
      bus_start();
      byte_out({dev, 1'b1}, a); acks += a;
      for (int k = 0; k < n; k++) begin byte_in(v, k != n - 1); rbuf[k] = v; end
      bus_stop();
   endtask

   task automatic apply_reset(input logic s);
      rst_n = 1'b0; strap = s;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R11 outputs in reset",
          {sda_oe, reg_we, reg_re}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_reset_state();
      apply_reset(1'b1);
      chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R11 outputs after reset",
          {sda_oe, reg_we, reg_re}, 0);
   endtask

   task automatic t_write_burst();
      int acks, w0;
      w0 = wn;
      do_write(8'h10, 3, 8'hC0, acks);
      chk(acks == 5, "R4 write acks", acks, 5);
      chk(wn - w0 == 3, "R5 write strobe count", wn - w0, 3);
      for (int k = 0; k < 3; k++) begin
         chk(wa[w0+k] == 7'(8'h10 + k), "R5 write address", wa[w0+k], 8'h10 + k);
         chk(wd[w0+k] == 8'hC0 + 8'(k), "R9 write data", wd[w0+k], 8'hC0 + k);
      end
   endtask

   task automatic t_wrap();
      int acks, w0;
      logic [6:0] e;
      w0 = wn; e = 7'h7E;
      do_write(8'h7E, 3, 8'h50, acks);
      chk(wn - w0 == 3, "R5 wrap strobe count", wn - w0, 3);
      for (int k = 0; k < 3; k++) begin
         chk(wa[w0+k] == e, "R5 wrap address", wa[w0+k], e);
         e = nxt(e);
      end
   endtask

   task automatic t_skip_write();
      int acks, w0;
      logic [6:0] e;
      w0 = wn; e = 7'h42;
      do_write(8'h42, 3, 8'h90, acks);
      for (int k = 0; k < 3; k++) begin
         chk(wa[w0+k] == e, "R6 skip write address", wa[w0+k], e);
         e = nxt(e);
      end
      chk(wa[w0+2] == 7'h45, "R6 0x43 followed by 0x45", wa[w0+2], 8'h45);
   endtask

   task automatic t_hold_write();
      int acks, w0;
      w0 = wn;
      do_write(8'h44, 2, 8'h3A, acks);
      chk(wn - w0 == 2 && wa[w0] == 7'h44 && wa[w0+1] == 7'h44, "R6 hold write address",
          {wa[w0], wa[w0+1]}, 16'h4444);
      chk(mem[7'h44] == 8'h3B, "R6 hold write last data", mem[7'h44], 8'h3B);
   endtask

   task automatic t_read_burst();
      int acks, r0;
      r0 = rn;
      do_read(8'h20, 3, acks);
      chk(acks == 3, "R4 read acks", acks, 3);
      chk(rn - r0 == 3, "R10 read strobe count", rn - r0, 3);
      for (int k = 0; k < 3; k++) begin
         chk(rbuf[k] == mem[7'h20 + 7'(k)], "R10 read data", rbuf[k], mem[7'h20 + 7'(k)]);
         chk(ra[r0+k] == 7'h20 + 7'(k), "R5 read address", ra[r0+k], 8'h20 + k);
      end
   endtask

   task automatic t_read_skip();
      int acks;
      do_read(8'h43, 2, acks);
      chk(rbuf[0] == mem[7'h43], "R6 read at 0x43", rbuf[0], mem[7'h43]);
      chk(rbuf[1] == mem[7'h45], "R6 read skips to 0x45", rbuf[1], mem[7'h45]);
   endtask

   task automatic t_read_hold();
      int acks, r0;
      r0 = rn;
      do_read(8'h44, 3, acks);
      for (int k = 0; k < 3; k++) begin
         chk(rbuf[k] == mem[7'h44], "R6 hold read data", rbuf[k], mem[7'h44]);
         chk(ra[r0+k] == 7'h44, "R6 hold read address", ra[r0+k], 8'h44);
      end
   endtask

   task automatic t_nack_release();
      int a, ones, r0;
      logic [7:0] v;
      logic b;
      r0 = rn; ones = 0;
      bus_start();
      byte_out({dev, 1'b0}, a);
      byte_out(8'h30, a);
      bus_start();
      byte_out({dev, 1'b1}, a);
      byte_in(v, 1'b0);
      for (int k = 0; k < 9; k++) begin bit_in(b); if (b) ones++; end
      bus_stop();
      chk(v == mem[7'h30], "R7 byte before nack", v, mem[7'h30]);
      chk(ones == 9, "R7 bus released after nack", ones, 9);
      chk(rn - r0 == 1, "R10 no fetch after nack", rn - r0, 1);
   endtask

   task automatic t_mismatch();
      int a, acks, w0;
      w0 = wn; acks = 0;
      bus_start();
      byte_out({7'h42, 1'b0}, a); acks += a;
      byte_out(8'h10, a); acks += a;
      byte_out(8'h55, a); acks += a;
      bus_stop();
      chk(acks == 0, "R8 no ack on mismatch", acks, 0);
      chk(wn == w0, "R8 no write on mismatch", wn - w0, 0);
   endtask

   task automatic t_no_start();
      int a, acks, w0, r0;
      w0 = wn; r0 = rn; acks = 0;
      m_scl = 1'b0; waitq();
      byte_out({dev, 1'b0}, a); acks += a;
      byte_out(8'h50, a); acks += a;
      byte_out(8'h66, a); acks += a;
      bus_stop();
      chk(acks == 0, "R2 no ack without START", acks, 0);
      chk(wn == w0 && rn == r0, "R2 no strobe without START", (wn - w0) + (rn - r0), 0);
   endtask

   task automatic t_stop_ends();
      int a, acks, w0;
      w0 = wn;
      do_write(8'h30, 1, 8'h3C, acks);
      m_scl = 1'b0; waitq();
      byte_out(8'h99, a);
      byte_out(8'h77, a);
      bus_stop();
      chk(wn - w0 == 1, "R9 STOP ends write", wn - w0, 1);
      chk(mem[7'h30] == 8'h3C, "R9 data kept after STOP", mem[7'h30], 8'h3C);
   endtask

   task automatic t_strap();
      int acks, a, w0;
      strap = 1'b0;
      do_write(8'h05, 1, 8'h21, acks);
      chk(acks == 3, "R1 strap change ignored", acks, 3);
      apply_reset(1'b0);
      w0 = wn;
      dev = 7'h40;
      do_write(8'h05, 1, 8'h77, acks);
      chk(acks == 3 && wn - w0 == 1 && wd[w0] == 8'h77, "R1 address 0x40 when strap low", acks, 3);
      bus_start();
      byte_out({7'h41, 1'b0}, a);
      bus_stop();
      chk(a == 0, "R1 0x41 rejected when strap low", a, 0);
   endtask

   initial begin
      t_reset_state();
      t_write_burst();
      t_wrap();
      t_skip_write();
      t_hold_write();
      t_read_burst();
      t_read_skip();
      t_read_hold();
      t_nack_release();
      t_mismatch();
      t_no_start();
      t_stop_ends();
      t_strap();
      chk(r3_bad == 0, "R3 sda_oe moved while SCL high", r3_bad, 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule